// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial bus placed in front of a 256-byte memory. It recovers start and stop conditions from over-sampled clock and data lines. It answers only to its own memory address, which is a fixed leading one followed by the value of six strap pins. It then carries out byte writes, page writes, current-address reads, random reads and sequential reads. One internal address counter serves every kind of access.

Incoming write data is collected in a one-page buffer. The buffer is moved into the array only when the stop condition that closes the write arrives. A programmable internal write time follows the commit, and `busy_o` is high for all of it. While the block is busy it does not acknowledge its address, so a bus master can poll for the end of the write. The array sits outside the block and has a write port and an asynchronous read port.

Top module: `i2c_mem_slave`

## Requirements
- R1: The first byte after a start is compared MSB first against {1, strap_i[5:0], rw}. On a match the block drives SDA low during the ninth clock. On a mismatch it leaves SDA released and ignores the bus until the next start.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. After reset and while the bus is idle, the SDA pull-down is off.
- R3: A write (rw=0) takes a word address byte and then data bytes, and every byte is acknowledged. The data reaches the memory only after the closing stop, at the addressed location.
- R4: In a write, after each data byte only the low 4 bits of the address counter advance. Data past the end of a 16-byte page wraps to the start of the same page and never touches another page.
- R5: A read (rw=1) that has no preceding word address returns the byte at the address counter. Every byte read or written leaves the counter one past the location accessed.
- R6: A word address write followed by a repeated start with rw=1 returns the byte at that word address.
- R7: While the master acknowledges each read byte, the block sends the byte at the next address. The counter wraps from 255 to 0.
- R8: After a master not-acknowledge the block keeps SDA released until the next start, even if SCL keeps toggling.
- R9: A stop that ends a write with at least one complete data byte starts an internal write of 16 + WR_CYCLES system clocks, and busy_o is high during it. While busy_o is high the address is not acknowledged.
- R10: A start that arrives before the closing stop discards the write data collected so far, including a start in the middle of a byte. Nothing is committed and busy_o stays low.
- R11: The SDA pull-down changes only while synchronized SCL is low, and memory writes happen only while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND) |
| strap_i | input | 6 | Device address strap pins |
| sda_pd_o | output | 1 | SDA pull-down enable |
| mem_raddr_o | output | 8 | Memory read address (the address counter) |
| mem_rdata_i | input | 8 | Memory read data, asynchronous |
| mem_we_o | output | 1 | Memory write strobe |
| mem_waddr_o | output | 8 | Memory write address |
| mem_wdata_o | output | 8 | Memory write data |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
A wrong address counter shows up at once as a wrong byte on the first read of the next transfer. Random, current-address and wrapping sequential reads each compare every returned byte with a shadow of the memory. A page buffer or commit fault appears only after the following stop, as a wrong memory image, an early or late fall of busy_o, or a write that lands outside its page. A bit engine that stays in the wrong state shows up within one bit time as a missing acknowledge, an extra acknowledge, or SDA held low after a not-acknowledge.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam int MEM_AW = 8;
  localparam int BYTE_W = 8;
  localparam int STRAP_W = 6;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_WADDR, ST_WADDR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK
  } bus_st_e;

  typedef enum logic [1:0] {CM_IDLE, CM_DRAIN, CM_WAIT} cm_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_mem_fsm.sv
module i2c_mem_fsm
  import i2c_mem_pkg::*;
#(
  parameter int PAGE_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic                 scl_rise_i,
  input  logic                 scl_fall_i,
  input  logic                 sda_i,
  input  logic [STRAP_W-1:0]   strap_i,
  input  logic                 busy_i,
  input  logic [BYTE_W-1:0]    rdata_i,
  output logic [MEM_AW-1:0]    ptr_o,
  output logic                 sda_pd_o,
  output logic                 push_o,
  output logic [PAGE_W-1:0]    push_idx_o,
  output logic [MEM_AW-PAGE_W-1:0] push_base_o,
  output logic [BYTE_W-1:0]    push_data_o
);
  bus_st_e st_q;
  logic [3:0] cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q;
  logic rw_q, nack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;  cnt_q <= '0;  sh_q <= '0;  tx_q <= '0;
      ptr_o <= '0;  sda_pd_o <= 1'b0;  rw_q <= 1'b0;  nack_q <= 1'b0;
      push_o <= 1'b0;  push_idx_o <= '0;  push_base_o <= '0;  push_data_o <= '0;
    end else begin
      push_o <= 1'b0;
      if (start_i) begin
        st_q <= ST_DEV;  cnt_q <= '0;  sda_pd_o <= 1'b0;
      end else if (stop_i) begin
        st_q <= ST_IDLE;  sda_pd_o <= 1'b0;
      end else if (scl_rise_i) begin
        case (st_q)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
            cnt_q <= cnt_q + 4'd1;
          end
          ST_RACK: nack_q <= sda_i;
          default: ;
        endcase
      end else if (scl_fall_i) begin
        case (st_q)
          ST_DEV: if (cnt_q == 4'd8) begin
            if (sh_q[7] && sh_q[6:1] == strap_i && !busy_i) begin
              st_q <= ST_DEV_ACK;  sda_pd_o <= 1'b1;  rw_q <= sh_q[0];
            end else st_q <= ST_IDLE;
          end
          ST_WADDR: if (cnt_q == 4'd8) begin
            ptr_o <= sh_q;  st_q <= ST_WADDR_ACK;  sda_pd_o <= 1'b1;
          end
          ST_WDATA: if (cnt_q == 4'd8) begin
            push_o      <= 1'b1;
            push_data_o <= sh_q;
            push_idx_o  <= ptr_o[PAGE_W-1:0];
            push_base_o <= ptr_o[MEM_AW-1:PAGE_W];
            // page roll-over: only the low bits advance
            ptr_o <= {ptr_o[MEM_AW-1:PAGE_W], ptr_o[PAGE_W-1:0] + 1'b1};
            st_q  <= ST_WDATA_ACK;  sda_pd_o <= 1'b1;
          end
          ST_DEV_ACK: begin
            if (rw_q) begin
              tx_q <= {rdata_i[6:0], 1'b0};  sda_pd_o <= ~rdata_i[7];
              cnt_q <= 4'd1;  st_q <= ST_RDATA;
            end else begin
              st_q <= ST_WADDR;  sda_pd_o <= 1'b0;  cnt_q <= '0;
            end
          end
          ST_WADDR_ACK, ST_WDATA_ACK: begin
            st_q <= ST_WDATA;  sda_pd_o <= 1'b0;  cnt_q <= '0;
          end
          ST_RDATA: begin
            if (cnt_q == 4'd8) begin
              sda_pd_o <= 1'b0;  st_q <= ST_RACK;  ptr_o <= ptr_o + 1'b1;
            end else begin
              sda_pd_o <= ~tx_q[7];  tx_q <= {tx_q[6:0], 1'b0};
              cnt_q <= cnt_q + 4'd1;
            end
          end
          ST_RACK: begin
            if (nack_q) st_q <= ST_IDLE;
            else begin
              tx_q <= {rdata_i[6:0], 1'b0};  sda_pd_o <= ~rdata_i[7];
              cnt_q <= 4'd1;  st_q <= ST_RDATA;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_page_commit.sv
module i2c_page_commit
  import i2c_mem_pkg::*;
#(
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 500_000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     stop_i,
  input  logic                     push_i,
  input  logic [PAGE_W-1:0]        push_idx_i,
  input  logic [MEM_AW-PAGE_W-1:0] push_base_i,
  input  logic [BYTE_W-1:0]        push_data_i,
  output logic                     busy_o,
  output logic                     we_o,
  output logic [MEM_AW-1:0]        waddr_o,
  output logic [BYTE_W-1:0]        wdata_o
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int WCW   = $clog2(WR_CYCLES + 1);
  localparam logic [PAGE_W-1:0] LAST = PAGE_W'(PAGE - 1);
  localparam logic [WCW-1:0]    WEND = WCW'(WR_CYCLES - 1);

  cm_st_e st_q;
  logic [BYTE_W-1:0] page_q [PAGE];
  logic [PAGE-1:0] vld_q;
  logic [MEM_AW-PAGE_W-1:0] base_q;
  logic [PAGE_W-1:0] idx_q;
  logic [WCW-1:0] wcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= CM_IDLE;  vld_q <= '0;  base_q <= '0;  idx_q <= '0;  wcnt_q <= '0;
      we_o <= 1'b0;  waddr_o <= '0;  wdata_o <= '0;
      for (int i = 0; i < PAGE; i++) page_q[i] <= '0;
    end else begin
      we_o <= 1'b0;
      case (st_q)
        CM_IDLE: begin
          if (push_i) begin
            page_q[push_idx_i] <= push_data_i;
            vld_q[push_idx_i]  <= 1'b1;
            base_q             <= push_base_i;
          end else if (clear_i) begin
            vld_q <= '0;
          end else if (stop_i && |vld_q) begin
            st_q <= CM_DRAIN;  idx_q <= '0;
          end
        end
        CM_DRAIN: begin
          we_o    <= vld_q[idx_q];
          waddr_o <= {base_q, idx_q};
          wdata_o <= page_q[idx_q];
          idx_q   <= idx_q + 1'b1;
          if (idx_q == LAST) begin
            st_q <= CM_WAIT;  wcnt_q <= '0;  vld_q <= '0;
          end
        end
        default: begin
          wcnt_q <= wcnt_q + 1'b1;
          if (wcnt_q == WEND) st_q <= CM_IDLE;
        end
      endcase
    end
  end

  assign busy_o = (st_q != CM_IDLE);
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter int PAGE_W      = 4,
  parameter int WR_CYCLES   = 500_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [5:0]        strap_i,
  output logic              sda_pd_o,
  output logic [7:0]        mem_raddr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              mem_we_o,
  output logic [7:0]        mem_waddr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              busy_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_s, stop_s;
  logic push;
  logic [PAGE_W-1:0] push_idx;
  logic [MEM_AW-PAGE_W-1:0] push_base;
  logic [BYTE_W-1:0] push_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_s), .stop_o(stop_s)
  );

  i2c_mem_fsm #(.PAGE_W(PAGE_W)) u_fsm (
    .clk_i, .rst_ni, .start_i(start_s), .stop_i(stop_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_s),
    .strap_i, .busy_i(busy_o), .rdata_i(mem_rdata_i),
    .ptr_o(mem_raddr_o), .sda_pd_o,
    .push_o(push), .push_idx_o(push_idx), .push_base_o(push_base), .push_data_o(push_data)
  );

  i2c_page_commit #(.PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_commit (
    .clk_i, .rst_ni, .clear_i(start_s), .stop_i(stop_s),
    .push_i(push), .push_idx_i(push_idx), .push_base_i(push_base), .push_data_i(push_data),
    .busy_o, .we_o(mem_we_o), .waddr_o(mem_waddr_o), .wdata_o(mem_wdata_o)
  );
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk #(
  parameter int PAGE_W = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s,
  input logic       stop_s,
  input logic       sda_pd,
  input logic       busy,
  input logic       we,
  input logic [7:0] waddr
);
  assert_we_in_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> busy);

  assert_pd_moves_scl_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_pd) |-> !scl_s);

  assert_commit_in_page_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we && $past(we)) |-> (waddr[7:PAGE_W] == $past(waddr[7:PAGE_W])));

  assert_busy_after_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(stop_s));

  assert_no_ack_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_pd);
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.PAGE_W(PAGE_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .stop_s(stop_s),
  .sda_pd(sda_pd_o), .busy(busy_o), .we(mem_we_o), .waddr(mem_waddr_o)
);

// File: tb/i2c_mem_slave_tb.sv
module i2c_mem_slave_tb_top;
  localparam int WR = 1000;
  localparam int PG = 16;
  localparam int Q  = 8;
  localparam logic [5:0] STRAP = 6'h2B;

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pd, we, busy;
  logic [7:0] raddr, rdata, waddr, wdata;
  logic sda_line;
  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  logic [7:0] exp_q [$], got_q [$];
  string tag_q [$];
  int checks = 0, errors = 0, cyc = 0, bad_we = 0;

  always #10 clk = ~clk;
  assign sda_line = m_sda & ~sda_pd;
  assign rdata = mem[raddr];

  i2c_mem_slave #(.WR_CYCLES(WR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line), .strap_i(STRAP),
    .sda_pd_o(sda_pd), .mem_raddr_o(raddr), .mem_rdata_i(rdata),
    .mem_we_o(we), .mem_waddr_o(waddr), .mem_wdata_o(wdata), .busy_o(busy)
  );

  function automatic logic [7:0] pat(int i);
    return 8'(i * 7 + 3);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int i = 0; i < 256; i++) mem[i] <= pat(i);
    else if (we) mem[waddr] <= wdata;
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected and received read bytes
  initial forever begin
    @(negedge clk);
    if (got_q.size() > 0 && exp_q.size() > 0) begin
      automatic logic [7:0] g = got_q.pop_front();
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(g == e, t, g, e);
    end
  end

  initial forever begin
    @(negedge clk);
    if (we && !busy) bad_we++;
  end

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic bit_io(input logic b, output logic s);
    m_sda = b; qw(); m_scl = 1'b1; qw(); s = sda_line; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic i_start();
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic i_stop();
    m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d, output logic ackline);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, s); d[i] = s; end
    bit_io(!mack, s);
    ackline = s;
  endtask

  // driver: pushes expected bytes, reads n bytes, nack on the last
  task automatic read_n(input logic [7:0] a, input int n, input string tag);
    logic [7:0] d; logic s;
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(shadow[8'(a + k)]);
      tag_q.push_back(tag);
      recv_byte(k < n - 1, d, s);
      got_q.push_back(d);
    end
    chk(s == 1'b1 && sda_pd == 1'b0, "R8 nack bit released", {s, sda_pd}, 2'b10);
  endtask

  task automatic rand_read(input logic [7:0] a, input int n, input string tag);
    logic ack;
    i_start(); send_byte({1'b1, STRAP, 1'b0}, ack);
    send_byte(a, ack);
    chk(ack, "R6 word address ack", ack, 1);
    i_start(); send_byte({1'b1, STRAP, 1'b1}, ack);
    chk(ack, "R6 read address ack", ack, 1);
    read_n(a, n, tag);
    i_stop();
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic ack; logic [7:0] d; logic s; int t0;
    for (int i = 0; i < 256; i++) shadow[i] = pat(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk(!sda_pd && !busy && !we, "R2 reset idle", {sda_pd, busy, we}, 0);

    // R1: wrong strap value is ignored
    i_start(); send_byte({1'b1, STRAP ^ 6'h01, 1'b0}, ack);
    chk(!ack, "R1 mismatch no ack", ack, 0);
    i_stop();
    i_start(); send_byte({1'b0, STRAP, 1'b0}, ack);
    chk(!ack, "R1 leading bit must be 1", ack, 0);
    i_stop();

    // R3 byte write 0x10 <- A5
    i_start(); send_byte({1'b1, STRAP, 1'b0}, ack);
    chk(ack, "R1 match ack (R2 start seen)", ack, 1);
    send_byte(8'h10, ack); chk(ack, "R3 word ack", ack, 1);
    send_byte(8'hA5, ack); chk(ack, "R3 data ack", ack, 1);
    chk(mem[8'h10] == pat(16), "R3 no commit before stop", mem[8'h10], pat(16));
    i_stop(); shadow[8'h10] = 8'hA5;
    t0 = cyc - Q;
    repeat (2) @(negedge clk);
    chk(busy, "R9 busy after stop", busy, 1);
    i_start(); send_byte({1'b1, STRAP, 1'b0}, ack);
    chk(!ack, "R9 no ack while busy", ack, 0);
    i_stop();
    chk(busy, "R9 still busy", busy, 1);
    while (busy) @(negedge clk);
    chk((cyc - t0) >= WR + PG && (cyc - t0) <= WR + PG + 8, "R9 busy length",
        cyc - t0, WR + PG);
    repeat (4) @(negedge clk);

    rand_read(8'h10, 1, "R6 random read");
    // R5: counter now 0x11
    i_start(); send_byte({1'b1, STRAP, 1'b1}, ack);
    chk(ack, "R5 read ack", ack, 1);
    read_n(8'h11, 1, "R5 current address read");
    i_stop();

    // R4 page write from 0x2E, four bytes wrap to 0x20
    i_start(); send_byte({1'b1, STRAP, 1'b0}, ack);
    send_byte(8'h2E, ack);
    for (int k = 0; k < 4; k++) begin
      send_byte(8'h11 * (k + 1), ack);
      chk(ack, "R4 page data ack", ack, 1);
      shadow[{4'h2, 4'(4'hE + k)}] = 8'(8'h11 * (k + 1));
    end
    i_stop();
    wait_idle();
    rand_read(8'h2E, 3, "R4 page end and next page intact");
    rand_read(8'h20, 3, "R4 page wrap");

    // R7 sequential read wrapping 255 -> 0, then R8 release after nack
    rand_read(8'hFE, 3, "R7 wrap");
    i_start(); send_byte({1'b1, STRAP, 1'b1}, ack);
    read_n(8'h01, 2, "R7 sequential continues");
    recv_byte(1'b0, d, s);
    chk(d == 8'hFF, "R8 released after nack", d, 8'hFF);
    i_stop();

    // R10 abort after complete data byte
    i_start(); send_byte({1'b1, STRAP, 1'b0}, ack);
    send_byte(8'h40, ack); send_byte(8'h77, ack);
    i_start(); i_stop();
    repeat (20) @(negedge clk);
    chk(!busy, "R10 aborted write not committed", busy, 0);
    // R10 abort mid-byte, then a full write to 0x42
    i_start(); send_byte({1'b1, STRAP, 1'b0}, ack);
    send_byte(8'h41, ack);
    for (int k = 0; k < 3; k++) bit_io(1'b0, s);
    i_start(); send_byte({1'b1, STRAP, 1'b0}, ack);
    chk(ack, "R10 engine back to address match", ack, 1);
    send_byte(8'h42, ack); send_byte(8'h55, ack);
    i_stop(); shadow[8'h42] = 8'h55;
    wait_idle();
    rand_read(8'h40, 3, "R10 abort left memory intact");

    chk(bad_we == 0, "R11 writes only while busy", bad_we, 0);
    begin
      automatic int mism = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) mism++;
      chk(mism == 0, "R3 memory image", mism, 0);
    end
    repeat (10) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog all requirements actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule